// File: doc/BRIEF.md
# DMA Channel Interrupt Enable and Status Bank

This block gathers per-channel event pulses from a multi-channel DMA engine and turns them into one interrupt request. Every channel has a 4-bit slot inside a pair of 32-bit registers, one register for enable and one for status. Each register holds the slots of eight channels, so a 16-channel engine uses two enable registers and two status registers. Three events are defined per channel: half of a transfer done, one descriptor done, and the whole descriptor queue done. Each event sets a sticky status bit.

Software reads status through a simple register port and acknowledges events by writing the value it read back to the same address. Every 1 written clears the matching bit. The interrupt line is the registered OR of every status bit whose enable bit is set. A separate one-bit gate register drives the engine's clock-gating enable.

Top module: `dmairq_bank`

## Requirements
- R1: After a synchronous reset, every enable bit, status bit, the gate bit, `irq_o`, `gate_o` and `rdata` are 0.
- R2: Enable registers sit at address 0x00 (channels 0–7) and 0x04 (channels 8–15). Channel c uses slot bits [4*(c mod 8)+2 : 4*(c mod 8)]. In a slot, bit 0 is half-done, bit 1 is descriptor-done and bit 2 is queue-done. A write stores the enable bits. A read with `rd_en` presents the register on `rdata` on the next cycle, and `rdata` then holds until the next read.
- R3: Status registers sit at 0x10 (channels 0–7) and 0x14 (channels 8–15), with the same slot layout as R2. On `evt_i`, channel c's half/descriptor/queue events are bits 3c, 3c+1 and 3c+2. A pulse sets its status bit whether or not the bit is enabled, and the bit stays set until software clears it.
- R4: Writing a status register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When an event and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R6: `irq_o` is 1 one cycle after some status bit and its enable bit are both 1. It returns to 0 one cycle after the last such pair stops being 1.
- R7: Writing 0 to both enable registers drops `irq_o` one cycle later, and the pending status bits are kept.
- R8: Bit 3 of every slot is reserved. It reads as 0 in enable and status registers, and writes to it have no effect.
- R9: The gate register at 0x20 keeps only bit 2, which drives `gate_o`. Writing 0x4 turns gating on. Other bits read as 0.
- R10: Writes to unmapped addresses change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data on `rdata` next cycle |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt_i | input | 48 | Event pulses, three per channel |
| irq_o | output | 1 | Registered interrupt request |
| gate_o | output | 1 | Engine clock-gating enable |

## Verification
A wrong bit inside a channel's status or enable slot reaches the pins in one of two ways. It shows on `irq_o` one cycle after the state goes wrong, provided the bit and its partner are both set. Otherwise it shows on `rdata` the cycle after software reads that register. A behavioural model follows every write, clear and event pulse and compares `irq_o`, `gate_o` and `rdata` on every clock. The model is driven both by directed stimulus and by a long random mix, so a lost event, a missed clear or a slot decoded into the wrong position shows up within a few cycles of the first read or enable touching it.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int SLOT_W     = 4;
  localparam int EVT_W      = 3;
  localparam int CH_PER_REG = 8;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int GATE_BIT   = 2;

  localparam logic [ADDR_W-1:0] EN_BASE   = 8'h00;
  localparam logic [ADDR_W-1:0] ST_BASE   = 8'h10;
  localparam logic [ADDR_W-1:0] GATE_ADDR = 8'h20;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_ST   = 2'd2,
    SEL_GATE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dmairq_slot.sv
module dmairq_slot
  import dmairq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en_wr,
  input  logic             st_wr,
  input  logic [EVT_W-1:0] wbits,
  input  logic [EVT_W-1:0] evt,
  output logic [EVT_W-1:0] en_q,
  output logic [EVT_W-1:0] st_q
);
  logic [EVT_W-1:0] clr_mask;

  assign clr_mask = st_wr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_wr) en_q <= wbits;
      st_q <= (st_q & ~clr_mask) | evt;
    end
  end

  // R5
  evt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((st_q & $past(evt)) == $past(evt)));

  // R4
  clr_done_chk: assert property (@(posedge clk) disable iff (rst)
    (st_wr && ((wbits & ~evt) != '0)) |=> ((st_q & $past(wbits & ~evt)) == '0));

  // R3
  st_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((evt == '0) && !st_wr) |=> $stable(st_q));
endmodule

// File: rtl/dmairq_decode.sv
module dmairq_decode
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int NB     = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [BANK_W-1:0] bank
);
  always_comb begin
    sel  = SEL_NONE;
    bank = '0;
    for (int b = 0; b < NB; b++) begin
      if (addr == ADDR_W'(int'(EN_BASE) + 4 * b)) begin
        sel  = SEL_EN;
        bank = BANK_W'(b);
      end
      if (addr == ADDR_W'(int'(ST_BASE) + 4 * b)) begin
        sel  = SEL_ST;
        bank = BANK_W'(b);
      end
    end
    if (addr == GATE_ADDR) sel = SEL_GATE;
  end
endmodule

// File: rtl/dmairq_rdmux.sv
module dmairq_rdmux
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int NB     = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int FLAT_W = NUM_CH * EVT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [BANK_W-1:0] bank,
  input  logic [FLAT_W-1:0] en_all,
  input  logic [FLAT_W-1:0] st_all,
  input  logic              gate_q,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    for (int k = 0; k < CH_PER_REG; k++) begin
      int ch;
      ch = int'(bank) * CH_PER_REG + k;
      if (ch < NUM_CH) begin
        if (sel == SEL_EN) word[k*SLOT_W +: EVT_W] = en_all[ch*EVT_W +: EVT_W];
        if (sel == SEL_ST) word[k*SLOT_W +: EVT_W] = st_all[ch*EVT_W +: EVT_W];
      end
    end
    if (sel == SEL_GATE) word[GATE_BIT] = gate_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= word;
  end
endmodule

// File: rtl/dmairq_bank.sv
module dmairq_bank
  import dmairq_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int NB     = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int FLAT_W = NUM_CH * EVT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [FLAT_W-1:0] evt_i,
  output logic              irq_o,
  output logic              gate_o
);
  reg_sel_e          sel;
  logic [BANK_W-1:0] bank;
  logic [FLAT_W-1:0] en_all;
  logic [FLAT_W-1:0] st_all;
  logic              gate_q;
  logic              irq_q;
  logic [DATA_W-1:0] rsv_mask;
  logic              unused_rsv_bits;

  dmairq_decode #(.NUM_CH(NUM_CH)) u_decode (
    .addr (addr),
    .sel  (sel),
    .bank (bank)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int B   = c / CH_PER_REG;
    localparam int POS = (c % CH_PER_REG) * SLOT_W;
    logic en_wr_c;
    logic st_wr_c;
    assign en_wr_c = wr_en && (sel == SEL_EN) && (bank == BANK_W'(B));
    assign st_wr_c = wr_en && (sel == SEL_ST) && (bank == BANK_W'(B));
    dmairq_slot u_slot (
      .clk   (clk),
      .rst   (rst),
      .en_wr (en_wr_c),
      .st_wr (st_wr_c),
      .wbits (wdata[POS +: EVT_W]),
      .evt   (evt_i[c*EVT_W +: EVT_W]),
      .en_q  (en_all[c*EVT_W +: EVT_W]),
      .st_q  (st_all[c*EVT_W +: EVT_W])
    );
  end

  always_comb begin
    rsv_mask = '0;
    for (int k = 0; k < CH_PER_REG; k++) rsv_mask[k*SLOT_W + SLOT_W - 1] = 1'b1;
  end
  assign unused_rsv_bits = ^(wdata & rsv_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en && (sel == SEL_GATE)) gate_q <= wdata[GATE_BIT];
      irq_q <= |(st_all & en_all);
    end
  end

  assign irq_o  = irq_q;
  assign gate_o = gate_q;

  dmairq_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .sel    (sel),
    .bank   (bank),
    .en_all (en_all),
    .st_all (st_all),
    .gate_q (gate_q),
    .rdata  (rdata)
  );

  // R6
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(|evt_i, 2) || $past(wr_en, 2)));

  // R9
  gate_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == GATE_ADDR)) |=> (gate_o == $past(wdata[GATE_BIT])));
endmodule

// File: tb/dmairq_bank_bench.sv
module dmairq_bank_bench;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [47:0] evt = '0;
  logic [31:0] rdata;
  logic        irq_o;
  logic        gate_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  dmairq_bank u_dmairq_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_i(evt), .irq_o(irq_o), .gate_o(gate_o)
  );

  // behavioural reference model
  int          m_en [NCH];
  int          m_st [NCH];
  bit          m_irq, m_gate;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 8; k++) begin
        if (a == 8'(4 * b))      r = r | (32'(m_en[b*8+k]) << (4 * k));
        if (a == 8'(16 + 4 * b)) r = r | (32'(m_st[b*8+k]) << (4 * k));
      end
    if (a == 8'h20) r[2] = m_gate;
    return r;
  endfunction

  always @(posedge clk) begin
    bit any;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin m_en[c] = 0; m_st[c] = 0; end
      m_irq = 0; m_gate = 0; m_rdata = '0;
    end else begin
      any = 0;
      for (int c = 0; c < NCH; c++) if ((m_en[c] & m_st[c]) != 0) any = 1;
      if (rd_en) m_rdata = m_read(addr);
      for (int c = 0; c < NCH; c++) begin
        int b, k, clr, ev;
        b = c / 8; k = c % 8; clr = 0;
        ev = int'((evt >> (3 * c)) & 48'h7);
        if (wr_en && addr == 8'(16 + 4 * b)) clr = int'((wdata >> (4 * k)) & 32'h7);
        m_st[c] = (m_st[c] & ~clr) | ev;
        if (wr_en && addr == 8'(4 * b)) m_en[c] = int'((wdata >> (4 * k)) & 32'h7);
      end
      if (wr_en && addr == 8'h20) m_gate = wdata[2];
      m_irq = any;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      check({phase, " irq_o"},  32'(irq_o),  32'(m_irq));
      check({phase, " gate_o"}, 32'(gate_o), 32'(m_gate));
      check({phase, " rdata"},  rdata, m_rdata);
    end
  end

  task automatic cyc(bit w, bit r, logic [7:0] a, logic [31:0] d, logic [47:0] e);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; evt = e;
    @(negedge clk);
    wr_en = 0; rd_en = 0; evt = '0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(1, 0, a, d, '0);
  endtask

  task automatic rd_expect(string req, logic [7:0] a, logic [31:0] exp);
    cyc(0, 1, a, '0, '0);
    check(req, rdata, exp);
  endtask

  task automatic pulse(logic [47:0] e);
    cyc(0, 0, 8'h00, '0, e);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    phase = "R1";
    check("R1 irq", 32'(irq_o), 0);
    check("R1 gate", 32'(gate_o), 0);
    rd_expect("R1 en0", 8'h00, 0);
    rd_expect("R1 en1", 8'h04, 0);
    rd_expect("R1 st0", 8'h10, 0);
    rd_expect("R1 st1", 8'h14, 0);
    rd_expect("R1 gate", 8'h20, 0);

    // R2 and R8 enable layout and reserved bit
    phase = "R2";
    wr(8'h00, 32'hFFFF_FFFF);
    rd_expect("R8 en0 reserved", 8'h00, 32'h7777_7777);
    wr(8'h04, 32'h0000_0420);
    rd_expect("R2 en1", 8'h04, 32'h0000_0420);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    rd_expect("R2 en0 cleared", 8'h00, 0);

    // R3 sticky status independent of enable
    phase = "R3";
    pulse(48'h1 | (48'h1 << 11) | (48'h1 << 37));
    check("R3 no irq when disabled", 32'(irq_o), 0);
    rd_expect("R3 st0", 8'h10, 32'h0000_4001);
    rd_expect("R3 st1", 8'h14, 32'h0002_0000);

    // R4 write-one clear
    phase = "R4";
    wr(8'h10, 32'h0000_0001);
    rd_expect("R4 clear one", 8'h10, 32'h0000_4000);
    wr(8'h10, 32'h0);
    rd_expect("R4 zero keeps", 8'h10, 32'h0000_4000);

    // R8 reserved status bits ignore writes
    phase = "R8";
    wr(8'h10, 32'h8888_8888);
    rd_expect("R8 st0 reserved", 8'h10, 32'h0000_4000);

    // R5 set beats clear
    phase = "R5";
    cyc(1, 0, 8'h14, 32'h0002_0000, 48'h1 << 37);
    rd_expect("R5 st1 kept", 8'h14, 32'h0002_0000);
    cyc(1, 0, 8'h10, 32'h0000_4000, 48'h1);
    rd_expect("R5 st0", 8'h10, 32'h0000_0001);

    // R6 interrupt timing
    phase = "R6";
    wr(8'h00, 32'h0000_0001);
    check("R6 irq not yet", 32'(irq_o), 0);
    @(negedge clk);
    check("R6 irq high", 32'(irq_o), 1);
    wr(8'h10, 32'h0000_0001);
    check("R6 irq one more cycle", 32'(irq_o), 1);
    @(negedge clk);
    check("R6 irq low", 32'(irq_o), 0);

    // R7 masking keeps status
    phase = "R7";
    pulse(48'h1 << 17);
    wr(8'h00, 32'h0040_0000);
    wr(8'h04, 32'h0002_0000);
    check("R7 irq before mask", 32'(irq_o), 1);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    @(negedge clk);
    check("R7 irq masked", 32'(irq_o), 0);
    rd_expect("R7 st0 kept", 8'h10, 32'h0040_0000);
    rd_expect("R7 st1 kept", 8'h14, 32'h0002_0000);

    // R9 gate register
    phase = "R9";
    wr(8'h20, 32'hFFFF_FFFF);
    check("R9 gate on", 32'(gate_o), 1);
    rd_expect("R9 gate read", 8'h20, 32'h0000_0004);
    wr(8'h20, 32'h0000_0003);
    check("R9 gate off", 32'(gate_o), 0);
    rd_expect("R9 gate read zero", 8'h20, 0);

    // R10 unmapped addresses
    phase = "R10";
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    rd_expect("R10 read hole", 8'h08, 0);
    rd_expect("R10 en0 untouched", 8'h00, 0);
    rd_expect("R10 st0 untouched", 8'h10, 32'h0040_0000);
    check("R10 gate untouched", 32'(gate_o), 0);

    // random mix against the model (R6)
    phase = "R6";
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      int sel;
      sel = int'($urandom % 5);
      a = (sel == 4) ? 8'h20 : ((sel >= 2) ? 8'(16 + 4 * (sel - 2)) : 8'(4 * sel));
      @(negedge clk);
      evt   = {16'($urandom & $urandom & $urandom), 32'($urandom & $urandom & $urandom)};
      wr_en = ($urandom % 3) == 0;
      rd_en = ($urandom % 2) == 0;
      addr  = a;
      wdata = $urandom;
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0; evt = '0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule